// File: doc/BRIEF.md
# Four-Channel Byte DMA Engine

This block is a bus master that copies single bytes from a source location to a destination location without processor help. It holds four channels, built as two identical two-channel groups. Each channel has its own source address, destination address, transfer count and control word. Either side of a copy may sit in memory space or in I/O space, so memory-to-memory, memory-to-I/O, I/O-to-memory and I/O-to-I/O copies are all possible.

A channel asks for service in one of three ways, chosen in its control word. It can follow an external request pin, which is synchronised to the clock first. It can follow a request line from an on-chip peripheral such as a timer or a serial port. It can also run on software command alone. A fixed-priority arbiter picks one channel while the bus is idle. The bus sequencer then runs a fetch bus cycle from the source and a deposit bus cycle to the destination. After the byte has been deposited, the addresses step and the count drops by one. When the count reaches zero, the channel turns itself off and raises a sticky terminal-count interrupt.

The bus side uses a valid/ready handshake. `bus_valid` stays high for the whole bus cycle. Address, space, direction and write data do not change during a cycle. The bus target applies back-pressure by holding `bus_ready` low. Each clock with `bus_ready` low in the third clock of a cycle adds one wait state. Read data is taken in the clock in which `bus_ready` is seen high.

Top module: `byte_dma`

## Requirements
- R1: After reset, `bus_valid` and all `tc_irq` bits are low, every channel is disabled, and the engine stays idle until a channel is enabled.
- R2: Each transfer is one fetch bus cycle (`bus_write`=0) at the channel's source address, followed directly by one deposit bus cycle (`bus_write`=1) at its destination address. `bus_wdata` carries the byte read in the fetch.
- R3: A bus cycle lasts four clocks while `bus_ready` is high. `bus_ready` is sampled from the third clock onward, and each clock in which it is low adds one clock. `bus_addr`, `bus_io` and `bus_write` stay stable through a cycle, and `bus_wdata` stays stable through a deposit.
- R4: A transfer starts one clock after an idle clock in which a channel requests. After every deposit the bus is idle for one clock, so back-to-back transfers with no wait states are 8 bus clocks plus 1 idle clock each.
- R5: Arbitration uses fixed priority, with channel 0 highest. A decision is made only in idle clocks, and a running transfer is never preempted.
- R6: The trigger field is control bits [8:7]. 0 follows `ext_req[n]` through a two-flop synchroniser. 1 follows `per_req[n]` directly. 2 requests whenever the channel is enabled. 3 never requests.
- R7: The source step field is control bits [4:3] and the destination step field is bits [6:5]. 1 adds one after each transfer, 2 subtracts one, and 0 or 3 holds the address.
- R8: Control bit 1 puts the source in I/O space and bit 2 puts the destination in I/O space. `bus_io` is high in exactly those bus cycles.
- R9: A channel requests only when enabled (control bit 0) and its count is non-zero. Each deposit lowers the count by one. The deposit that brings the count to zero clears the enable bit and sets `tc_irq[n]`, which stays set.
- R10: Writes select register `cfg_reg` of channel `cfg_ch`: 0 is source, 1 is destination, 2 is count, 3 is control. A control write clears `tc_irq[n]`. A write takes priority over the end-of-transfer update in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel being written |
| cfg_reg | input | 2 | Register select (0 source, 1 destination, 2 count, 3 control) |
| cfg_wdata | input | 20 | Write data |
| ext_req | input | 4 | Asynchronous external request pins, one per channel |
| per_req | input | 4 | Synchronous peripheral request lines, one per channel |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_ready | input | 1 | Target ready; low in the third clock or later inserts a wait state |
| bus_write | output | 1 | 0 for fetch, 1 for deposit |
| bus_io | output | 1 | 1 selects I/O space, 0 memory space |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 8 | Byte to deposit |
| bus_rdata | input | 8 | Byte returned by the fetch |
| tc_irq | output | 4 | Sticky terminal-count interrupts |

## Verification
Assertions check the bus protocol on every clock. A fetch always comes first and a deposit always follows a fetch. No segment of a bus cycle is shorter than four clocks. Address, space and deposit data hold through a cycle. The bus goes idle after each deposit, a grant is made only while idle, a terminal-count bit falls only after a control write, and a channel that has just reached terminal count stops requesting. Some properties are not local to one clock: the order in which competing channels are served, address stepping across transfers, the two-clock synchroniser delay, the triggers that must never fire, and the exact cycle of every wait state. Only the bench scenarios, compared clock by clock against a behavioural model, can show these.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_KEEP = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    TRIG_PIN    = 2'd0,
    TRIG_PERIPH = 2'd1,
    TRIG_SOFT   = 2'd2,
    TRIG_OFF    = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    REG_SRC  = 2'd0,
    REG_DST  = 2'd1,
    REG_CNT  = 2'd2,
    REG_CTRL = 2'd3
  } reg_e;

  // Field layout of the control word, bit 0 upward: en, src_io, dst_io,
  // src_step[4:3], dst_step[6:5], trig[8:7].
  typedef struct packed {
    trig_e trig;
    step_e dst_step;
    step_e src_step;
    logic  dst_io;
    logic  src_io;
    logic  en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_F1   = 4'd1,
    S_F2   = 4'd2,
    S_F3   = 4'd3,
    S_F4   = 4'd4,
    S_D1   = 4'd5,
    S_D2   = 4'd6,
    S_D3   = 4'd7,
    S_D4   = 4'd8
  } seq_e;

endpackage

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_e          wr_reg,
  input  logic [AW-1:0] wr_data,
  input  logic          pin_req,
  input  logic          per_req,
  input  logic          done,
  output logic          req,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output ctrl_t         ctrl,
  output logic          tc
);

  logic [CW-1:0] cnt_q;
  logic          trig_hit;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input step_e s);
    case (s)
      STEP_UP:   step_addr = a + AW'(1);
      STEP_DOWN: step_addr = a - AW'(1);
      default:   step_addr = a;
    endcase
  endfunction

  always_comb begin
    case (ctrl.trig)
      TRIG_PIN:    trig_hit = pin_req;
      TRIG_PERIPH: trig_hit = per_req;
      TRIG_SOFT:   trig_hit = 1'b1;
      default:     trig_hit = 1'b0;
    endcase
  end

  assign req = ctrl.en && (cnt_q != '0) && trig_hit;

  // End-of-transfer update first, register write after it so the write wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      cnt_q    <= '0;
      ctrl     <= '0;
      tc       <= 1'b0;
    end else begin
      if (done) begin
        src_addr <= step_addr(src_addr, ctrl.src_step);
        dst_addr <= step_addr(dst_addr, ctrl.dst_step);
        cnt_q    <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          ctrl.en <= 1'b0;
          tc      <= 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_reg)
          REG_SRC: src_addr <= wr_data;
          REG_DST: dst_addr <= wr_data;
          REG_CNT: cnt_q    <= wr_data[CW-1:0];
          default: begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            tc   <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_pair.sv
module dma_pair
  import dma_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          wr_en,
  input  reg_e                wr_reg,
  input  logic [AW-1:0]       wr_data,
  input  logic [1:0]          pin_req,
  input  logic [1:0]          per_req,
  input  logic [1:0]          done,
  output logic [1:0]          req,
  output logic [1:0][AW-1:0]  src_addr,
  output logic [1:0][AW-1:0]  dst_addr,
  output ctrl_t [1:0]         ctrl,
  output logic [1:0]          tc
);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    dma_channel #(.AW(AW), .CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en[c]),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data),
      .pin_req  (pin_req[c]),
      .per_req  (per_req[c]),
      .done     (done[c]),
      .req      (req[c]),
      .src_addr (src_addr[c]),
      .dst_addr (dst_addr[c]),
      .ctrl     (ctrl[c]),
      .tc       (tc[c])
    );
  end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] st_src,
  input  logic [AW-1:0] st_dst,
  input  logic          st_src_io,
  input  logic          st_dst_io,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          idle,
  output logic          done
);

  seq_e          state_q;
  logic [AW-1:0] src_q, dst_q;
  logic          src_io_q, dst_io_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      src_io_q <= 1'b0;
      dst_io_q <= 1'b0;
      data_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          src_q    <= st_src;
          dst_q    <= st_dst;
          src_io_q <= st_src_io;
          dst_io_q <= st_dst_io;
          state_q  <= S_F1;
        end
        S_F1: state_q <= S_F2;
        S_F2: state_q <= S_F3;
        S_F3: if (bus_ready) begin
          data_q  <= bus_rdata;
          state_q <= S_F4;
        end
        S_F4: state_q <= S_D1;
        S_D1: state_q <= S_D2;
        S_D2: state_q <= S_D3;
        S_D3: if (bus_ready) state_q <= S_D4;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == S_IDLE);
  assign done      = (state_q == S_D4);
  assign bus_valid = !idle;
  assign bus_write = (state_q >= S_D1);
  assign bus_addr  = bus_write ? dst_q : src_q;
  assign bus_io    = bus_write ? dst_io_q : src_io_q;
  assign bus_wdata = data_q;

endmodule

// File: rtl/byte_dma.sv
module byte_dma
  import dma_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned AW          = 20,
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_PAIRS  = NUM_CH / 2,
  localparam int unsigned CHW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [1:0]        cfg_reg,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic [NUM_CH-1:0] ext_req,
  input  logic [NUM_CH-1:0] per_req,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic              bus_io,
  output logic [AW-1:0]     bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic [NUM_CH-1:0] tc_irq
);

  logic [SYNC_STAGES-1:0][NUM_CH-1:0] sync_q;
  logic [NUM_CH-1:0]          pin_sync;
  logic [NUM_CH-1:0]          wr_en_vec;
  logic [NUM_CH-1:0]          done_vec;
  logic [NUM_CH-1:0]          chan_req;
  logic [NUM_CH-1:0][AW-1:0]  src_all;
  logic [NUM_CH-1:0][AW-1:0]  dst_all;
  ctrl_t [NUM_CH-1:0]         ctrl_all;
  reg_e                       cfg_reg_e;
  logic                       arb_any;
  logic [CHW-1:0]             arb_idx;
  logic [CHW-1:0]             grant_q;
  logic                       seq_idle;
  logic                       seq_done;
  logic                       seq_start;

  // Request pin synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= ext_req;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end
  assign pin_sync  = sync_q[SYNC_STAGES-1];
  assign cfg_reg_e = reg_e'(cfg_reg);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wr_en_vec[i] = cfg_we && (cfg_ch == CHW'(i));
      done_vec[i]  = seq_done && (grant_q == CHW'(i));
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dma_pair #(.AW(AW), .CW(CW)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_vec[2*p +: 2]),
      .wr_reg   (cfg_reg_e),
      .wr_data  (cfg_wdata),
      .pin_req  (pin_sync[2*p +: 2]),
      .per_req  (per_req[2*p +: 2]),
      .done     (done_vec[2*p +: 2]),
      .req      (chan_req[2*p +: 2]),
      .src_addr (src_all[2*p +: 2]),
      .dst_addr (dst_all[2*p +: 2]),
      .ctrl     (ctrl_all[2*p +: 2]),
      .tc       (tc_irq[2*p +: 2])
    );
  end

  dma_prio_arb #(.N(NUM_CH)) u_arb (
    .req (chan_req),
    .any (arb_any),
    .idx (arb_idx)
  );

  assign seq_start = seq_idle && arb_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         grant_q <= '0;
    else if (seq_start) grant_q <= arb_idx;
  end

  dma_bus_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .st_src    (src_all[arb_idx]),
    .st_dst    (dst_all[arb_idx]),
    .st_src_io (ctrl_all[arb_idx].src_io),
    .st_dst_io (ctrl_all[arb_idx].dst_io),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_io    (bus_io),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .idle      (seq_idle),
    .done      (seq_done)
  );

endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned AW     = 20,
  localparam int unsigned CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_start,
  input logic              seq_done,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_io,
  input logic [AW-1:0]     bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [NUM_CH-1:0] chan_req,
  input logic [NUM_CH-1:0] tc_irq,
  input logic              cfg_we,
  input logic [CHW-1:0]    cfg_ch,
  input logic [1:0]        cfg_reg
);

  logic       prev_valid, prev_write;
  logic [3:0] seg_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_write <= 1'b0;
      seg_len    <= '0;
    end else begin
      prev_valid <= bus_valid;
      prev_write <= bus_write;
      if (!bus_valid) seg_len <= '0;
      else if (prev_valid && (prev_write == bus_write))
        seg_len <= (seg_len == 4'hF) ? seg_len : seg_len + 4'd1;
      else seg_len <= 4'd1;
    end
  end

  AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> bus_valid && !bus_write); // R2
  AST_DEPOSIT_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_write) |-> $past(bus_valid) && !$past(bus_write)); // R2
  AST_DONE_IN_DEPOSIT: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> bus_valid && bus_write); // R2
  AST_SEGMENT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_write) || $fell(bus_valid)) |-> seg_len >= 4'd4); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && prev_valid && (bus_write == prev_write)) |-> $stable(bus_addr) && $stable(bus_io)); // R3
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && prev_valid && prev_write) |-> $stable(bus_wdata)); // R3
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !bus_valid); // R4
  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !bus_valid); // R5

  for (genvar i = 0; i < NUM_CH; i++) begin : g_tc
    AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc_irq[i]) |-> $past(cfg_we && (cfg_ch == CHW'(i)) && (cfg_reg == 2'd3))); // R10
    AST_TC_STOPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_irq[i]) |-> !chan_req[i]); // R9
  end

endmodule

bind byte_dma dma_checker #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seq_start (seq_start),
  .seq_done  (seq_done),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_io    (bus_io),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .chan_req  (chan_req),
  .tc_irq    (tc_irq),
  .cfg_we    (cfg_we),
  .cfg_ch    (cfg_ch),
  .cfg_reg   (cfg_reg)
);

// File: tb/byte_dma_bench.sv
`timescale 1ns/1ps
module byte_dma_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_reg = '0;
  logic [19:0] cfg_wdata = '0;
  logic [3:0]  ext_req = '0;
  logic [3:0]  per_req = '0;
  logic        bus_valid, bus_write, bus_io;
  logic        bus_ready = 1'b1;
  logic [19:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [3:0]  tc_irq;

  int errors = 0;
  int checks = 0;
  int tick = 0;

  always #2.5 clk = ~clk;

  byte_dma u_byte_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
    .cfg_wdata(cfg_wdata), .ext_req(ext_req), .per_req(per_req),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tc_irq(tc_irq)
  );

  // Memory model: data is a function of address and space
  assign bus_rdata = bus_addr[7:0] ^ {bus_io, 7'h15};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_src[4], m_dst[4], m_cnt[4], m_ss[4], m_ds[4], m_trig[4];
  bit m_en[4], m_sio[4], m_dio[4], m_tc[4];
  int m_phase, m_g, m_ls, m_ld;
  bit m_lsio, m_ldio;
  bit [7:0] m_data;
  bit [3:0] m_s1, m_s2;

  function automatic int step(input int a, input int s);
    if (s == 1) return (a + 1) & 20'hFFFFF;
    if (s == 2) return (a - 1) & 20'hFFFFF;
    return a;
  endfunction

  function automatic bit mreq(input int i);
    bit t;
    case (m_trig[i])
      0: t = m_s2[i];
      1: t = per_req[i];
      2: t = 1'b1;
      default: t = 1'b0;
    endcase
    return m_en[i] && (m_cnt[i] != 0) && t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_ss[i] = 0; m_ds[i] = 0;
        m_trig[i] = 0; m_en[i] = 0; m_sio[i] = 0; m_dio[i] = 0; m_tc[i] = 0;
      end
      m_phase = 0; m_g = 0; m_ls = 0; m_ld = 0; m_lsio = 0; m_ldio = 0;
      m_data = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      case (m_phase)
        0: begin
          for (int i = 3; i >= 0; i--) if (mreq(i)) m_g = i;
          if (mreq(0) || mreq(1) || mreq(2) || mreq(3)) begin
            m_ls = m_src[m_g]; m_ld = m_dst[m_g];
            m_lsio = m_sio[m_g]; m_ldio = m_dio[m_g];
            m_phase = 1;
          end
        end
        3: if (bus_ready) begin m_data = bus_rdata; m_phase = 4; end
        7: if (bus_ready) m_phase = 8;
        8: begin
          m_src[m_g] = step(m_src[m_g], m_ss[m_g]);
          m_dst[m_g] = step(m_dst[m_g], m_ds[m_g]);
          if (m_cnt[m_g] == 1) begin m_en[m_g] = 0; m_tc[m_g] = 1; end
          m_cnt[m_g] = (m_cnt[m_g] - 1) & 16'hFFFF;
          m_phase = 0;
        end
        default: m_phase = m_phase + 1;
      endcase
      if (cfg_we) begin
        case (cfg_reg)
          0: m_src[cfg_ch] = cfg_wdata;
          1: m_dst[cfg_ch] = cfg_wdata;
          2: m_cnt[cfg_ch] = cfg_wdata[15:0];
          default: begin
            m_en[cfg_ch] = cfg_wdata[0]; m_sio[cfg_ch] = cfg_wdata[1];
            m_dio[cfg_ch] = cfg_wdata[2]; m_ss[cfg_ch] = cfg_wdata[4:3];
            m_ds[cfg_ch] = cfg_wdata[6:5]; m_trig[cfg_ch] = cfg_wdata[8:7];
            m_tc[cfg_ch] = 0;
          end
        endcase
      end
      m_s2 = m_s1;
      m_s1 = ext_req;
    end
  end

  // Clock-by-clock comparison, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      bit ev, ew, eio;
      int ea;
      bit [3:0] etc;
      ev  = (m_phase != 0);
      ew  = (m_phase >= 5);
      ea  = ew ? m_ld : m_ls;
      eio = ew ? m_ldio : m_lsio;
      etc = {m_tc[3], m_tc[2], m_tc[1], m_tc[0]};
      chk(bus_valid == ev, "R3 R4 R5 bus_valid", bus_valid, ev);
      if (ev) begin
        chk(bus_write == ew, "R2 bus_write", bus_write, ew);
        chk(bus_addr == ea[19:0], "R7 bus_addr", bus_addr, ea);
        chk(bus_io == eio, "R8 bus_io", bus_io, eio);
        if (ew) chk(bus_wdata == m_data, "R2 bus_wdata", bus_wdata, m_data);
      end
      chk(tc_irq == etc, "R9 tc_irq", tc_irq, etc);
    end
  end

  // Monitors
  bit ready_mode = 0;
  int n_valid, n_io_wr, first_v, last_v;
  bit prev_v = 0;
  int fetch_log[$];
  always @(negedge clk) begin
    tick++;
    bus_ready = ready_mode ? ((tick % 3) != 0) : 1'b1;
    if (bus_valid) begin
      n_valid++;
      if (first_v < 0) first_v = tick;
      last_v = tick;
      if (bus_write && bus_io) n_io_wr++;
      if (!prev_v) fetch_log.push_back(int'(bus_addr));
    end
    prev_v = bus_valid;
  end

  task automatic clear_mon();
    n_valid = 0; n_io_wr = 0; first_v = -1; last_v = -1;
    fetch_log.delete();
  endtask

  task automatic wr(input int ch, input int r, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch[1:0]; cfg_reg = r[1:0]; cfg_wdata = d[19:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic int mkc(input int en, input int sio, input int dio,
                             input int ss, input int ds, input int trig);
    return en | (sio << 1) | (dio << 2) | (ss << 3) | (ds << 5) | (trig << 7);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (tick > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1: reset state
    chk(bus_valid == 0, "R1 bus_valid after reset", bus_valid, 0);
    chk(tc_irq == 0, "R1 tc_irq after reset", tc_irq, 0);
    clear_mon();
    idle(8);
    chk(n_valid == 0, "R1 idle while disabled", n_valid, 0);

    // Scenario A: channel 1, software, memory -> fixed I/O port, 3 bytes
    wr(1, 0, 'h00100); wr(1, 1, 'h00080); wr(1, 2, 3);
    clear_mon();
    wr(1, 3, mkc(1, 0, 1, 1, 0, 2));
    idle(40);
    chk(n_valid == 24, "R3 bus clocks for 3 transfers", n_valid, 24);
    chk(last_v - first_v + 1 == 26, "R4 span incl idle gaps", last_v - first_v + 1, 26);
    chk(n_io_wr == 12, "R8 io deposit clocks", n_io_wr, 12);
    chk(tc_irq[1] == 1, "R9 tc after count", tc_irq[1], 1);

    // Scenario B: competing channels, wait states
    wr(0, 0, 'h00230); wr(0, 1, 'h00010); wr(0, 2, 2);
    wr(0, 3, mkc(1, 1, 1, 2, 1, 1));
    wr(2, 0, 'h40000); wr(2, 1, 'h50000); wr(2, 2, 2);
    wr(2, 3, mkc(1, 0, 0, 0, 1, 0));
    wr(3, 0, 'h00777); wr(3, 1, 'h00020); wr(3, 2, 1);
    wr(3, 3, mkc(1, 0, 1, 1, 0, 1));
    clear_mon();
    ready_mode = 1;
    @(negedge clk);
    per_req = 4'b1001; ext_req = 4'b0100;
    idle(150);
    ready_mode = 0;
    per_req = 0; ext_req = 0;
    chk(fetch_log.size() == 5, "R5 transfer count", fetch_log.size(), 5);
    if (fetch_log.size() == 5) begin
      chk(fetch_log[0] == 'h230, "R5 first grant ch0", fetch_log[0], 'h230);
      chk(fetch_log[1] == 'h22F, "R7 decrement source", fetch_log[1], 'h22F);
      chk(fetch_log[2] == 'h40000, "R5 then ch2", fetch_log[2], 'h40000);
      chk(fetch_log[3] == 'h40000, "R7 held source", fetch_log[3], 'h40000);
      chk(fetch_log[4] == 'h777, "R5 ch3 last", fetch_log[4], 'h777);
    end
    chk(tc_irq == 4'hF, "R9 all terminal counts", tc_irq, 4'hF);

    // Scenario C: control write clears only that channel's flag
    wr(1, 3, 0);
    @(negedge clk);
    chk(tc_irq == 4'b1101, "R10 tc clear by control write", tc_irq, 4'b1101);

    // Scenario D: trigger off, and zero count
    per_req = 4'hF; ext_req = 4'hF;
    wr(1, 2, 2);
    clear_mon();
    wr(1, 3, mkc(1, 0, 0, 1, 1, 3));
    idle(30);
    chk(n_valid == 0, "R6 trigger code 3 never requests", n_valid, 0);
    wr(1, 2, 0);
    clear_mon();
    wr(1, 3, mkc(1, 0, 0, 1, 1, 2));
    idle(30);
    chk(n_valid == 0, "R9 zero count no transfer", n_valid, 0);
    chk(tc_irq[1] == 0, "R9 zero count no flag", tc_irq[1], 0);
    wr(1, 3, 0);
    per_req = 0; ext_req = 0;
    idle(4);

    // Scenario E: pin synchroniser latency
    wr(2, 0, 'h00100); wr(2, 1, 'h00200); wr(2, 2, 1);
    clear_mon();
    wr(2, 3, mkc(1, 0, 0, 0, 0, 0));
    idle(10);
    chk(n_valid == 0, "R6 pin low no request", n_valid, 0);
    ext_req[2] = 1;
    @(negedge clk);
    chk(bus_valid == 0, "R6 sync stage 1", bus_valid, 0);
    @(negedge clk);
    chk(bus_valid == 0, "R6 sync stage 2", bus_valid, 0);
    @(negedge clk);
    chk(bus_valid == 1, "R6 transfer after sync", bus_valid, 1);
    idle(20);
    ext_req = 0;
    chk(tc_irq[2] == 1, "R9 pin transfer done", tc_irq[2], 1);

    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule